// File: doc/BRIEF.md
# SAR Converter Control Sequencer

This block is the digital sequencer of a successive-approximation analog-to-digital converter. It runs on the external conversion clock and watches an active-low convert request and an active-low chip select. When a conversion is accepted, it puts the analog front end into hold and raises `busy`. It then walks a one-hot trial bit from the most significant bit down to the least significant bit. At each step it reads a single comparator bit to decide whether that trial bit stays set.

The search word goes to the capacitor DAC in offset binary. When the search ends, the result is converted to two's complement and stored in an output register. The register feeds a parallel read port that has a drive enable, so that a pad ring can build a three-state bus from it. The read port can present the whole word, or it can move the upper byte onto the low data lines for a narrow host.

Each conversion frame has a fixed length of `FRAME` clocks. The result is stored on clock `W+1` of the frame, and the clocks that follow are the acquisition period. Convert requests that arrive while a frame is running are discarded.

Top module: `sar_seq_top`

## Requirements
- R1: After reset, `busy`, `hold` and `bus_oe` are low and the output register holds zero.
- R2: A conversion is accepted only when `conv_n` is sampled high at one rising edge and low at the next edge while `cs_n` is low and no frame is running; a falling `conv_n` with `cs_n` high starts nothing.
- R3: `hold` goes high in the same cycle in which an acceptable fall of `conv_n` is present, before any clock edge, and stays high for the whole conversion; it is low during acquisition and idle.
- R4: `busy` rises at the accepting edge (clock 1) and falls at clock `W+1` (17 by default), so it is high for exactly `W` sampled cycles; a frame lasts `FRAME` (20) clocks, and the earliest next accepting edge is clock `FRAME+1`.
- R5: `dac_word` is offset binary. At clock 1 it becomes 0x8000. At each later conversion edge the current trial bit is kept when `cmp_in` is 1 (DAC level at or below the input), then the next lower bit is set.
- R6: At clock `W+1` the output register takes the final search word with its MSB inverted (two's complement), so inputs of 0xFFFF, 0x8000 and 0x0000 in offset binary read as 0x7FFF, 0x0000 and 0x8000.
- R7: While a frame is running, further falls of `conv_n` are discarded, and a `conv_n` held low through the end of the frame starts no new conversion.
- R8: `bus_oe` is high only while both `cs_n` and `rd_n` are low.
- R9: With `byte_sel` low, `bus_q` carries the full result. With `byte_sel` high, `bus_q[7:0]` carries result bits 15..8 and `bus_q[15:8]` is zero. The selection is combinational and takes effect without a clock edge.
- R10: The output register keeps its value until the next clock `W+1` store, and reading has no effect on `busy` or on the stored result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_n | input | 1 | Convert request, active low, edge sensitive |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| byte_sel | input | 1 | 1: upper byte on low lines |
| cmp_in | input | 1 | Comparator, 1 when DAC level is at or below the input |
| dac_word | output | 16 | Trial word to the DAC, offset binary |
| hold | output | 1 | 1: sample switch open (hold) |
| busy | output | 1 | Conversion in progress |
| bus_q | output | 16 | Read data |
| bus_oe | output | 1 | Drive enable for the read data |

## Verification
A read and the result store can fall in the same cycle. The bench holds `cs_n` and `rd_n` low across clock 17 while it toggles `byte_sel`, and it compares the port word on every cycle against a behavioural model. That comparison must show the old value up to the store edge and the new value right after it, with `busy` unaffected by the read. A second collision is a new convert fall in the same cycle as the end of a frame or the store. The bench places request pulses inside the frame, keeps `conv_n` low through the frame boundary, and checks that `busy` rises only for a fresh fall at or after clock 21.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int DEF_DATA_W = 16;
    localparam int DEF_FRAME  = 20;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CONV = 2'd1,
        PH_ACQ  = 2'd2
    } phase_e;

    // Two's complement view of an offset-binary code: flip the MSB.
    function automatic logic [DEF_DATA_W-1:0] offset_to_twos(input logic [DEF_DATA_W-1:0] code);
        return {~code[DEF_DATA_W-1], code[DEF_DATA_W-2:0]};
    endfunction

endpackage

// File: rtl/sar_start_detect.sv
module sar_start_detect (
    input  logic clk,
    input  logic rst,
    input  logic conv_n,
    input  logic cs_n,
    input  logic idle,
    output logic start_req
);
    logic conv_q;

    always_ff @(posedge clk) begin
        if (rst) conv_q <= 1'b1;
        else     conv_q <= conv_n;
    end

    // Edge seen between the last sample and the present level.
    assign start_req = conv_q & ~conv_n & ~cs_n & idle;
endmodule

// File: rtl/sar_step_engine.sv
module sar_step_engine
    import sar_seq_pkg::*;
#(
    parameter int W     = DEF_DATA_W,
    parameter int FRAME = DEF_FRAME
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_req,
    input  logic         cmp_in,
    output logic [W-1:0] dac_word,
    output logic [W-1:0] result,
    output logic         in_conv,
    output logic         idle
);
    localparam int CW = $clog2(FRAME + 1);
    localparam logic [W-1:0] MSB_ONE  = {1'b1, {(W-1){1'b0}}};
    localparam logic [CW-1:0] STORE_CNT = CW'(W + 1);
    localparam logic [CW-1:0] LAST_CNT  = CW'(FRAME - 1);

    phase_e       phase;
    logic [CW-1:0] cnt;
    logic [W-1:0] trial;
    logic [W-1:0] mask;
    logic [W-1:0] kept;

    always_comb begin
        kept = cmp_in ? trial : (trial & ~mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            trial  <= '0;
            mask   <= '0;
            result <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start_req) begin
                        phase <= PH_CONV;
                        cnt   <= CW'(1);
                        trial <= MSB_ONE;
                        mask  <= MSB_ONE;
                    end
                end
                PH_CONV: begin
                    cnt <= cnt + 1'b1;
                    if (mask[0]) begin
                        result <= {~kept[W-1], kept[W-2:0]};
                        phase  <= PH_ACQ;
                        cnt    <= STORE_CNT;
                        trial  <= '0;
                        mask   <= '0;
                    end else begin
                        trial <= kept | (mask >> 1);
                        mask  <= mask >> 1;
                    end
                end
                PH_ACQ: begin
                    if (cnt == LAST_CNT) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign dac_word = trial;
    assign in_conv  = (phase == PH_CONV);
    assign idle     = (phase == PH_IDLE);
endmodule

// File: rtl/sar_out_bus.sv
module sar_out_bus #(
    parameter int W = 16
) (
    input  logic         cs_n,
    input  logic         rd_n,
    input  logic         byte_sel,
    input  logic [W-1:0] result,
    output logic [W-1:0] bus_q,
    output logic         bus_oe
);
    localparam int HALF = W / 2;

    generate
        if (W % 2 == 0) begin : g_even
            always_comb begin
                bus_q = byte_sel ? {{HALF{1'b0}}, result[W-1:HALF]} : result;
            end
        end else begin : g_odd
            always_comb begin
                bus_q = byte_sel ? {{(W-HALF){1'b0}}, result[W-1:W-HALF]} : result;
            end
        end
    endgenerate

    assign bus_oe = ~cs_n & ~rd_n;
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
    import sar_seq_pkg::*;
#(
    parameter int W     = DEF_DATA_W,
    parameter int FRAME = DEF_FRAME
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         conv_n,
    input  logic         cs_n,
    input  logic         rd_n,
    input  logic         byte_sel,
    input  logic         cmp_in,
    output logic [W-1:0] dac_word,
    output logic         hold,
    output logic         busy,
    output logic [W-1:0] bus_q,
    output logic         bus_oe
);
    logic         start_req;
    logic         idle;
    logic         in_conv;
    logic [W-1:0] result;

    sar_start_detect u_start (
        .clk       (clk),
        .rst       (rst),
        .conv_n    (conv_n),
        .cs_n      (cs_n),
        .idle      (idle),
        .start_req (start_req)
    );

    sar_step_engine #(.W(W), .FRAME(FRAME)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .start_req(start_req),
        .cmp_in   (cmp_in),
        .dac_word (dac_word),
        .result   (result),
        .in_conv  (in_conv),
        .idle     (idle)
    );

    sar_out_bus #(.W(W)) u_bus (
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .byte_sel (byte_sel),
        .result   (result),
        .bus_q    (bus_q),
        .bus_oe   (bus_oe)
    );

    // Hold opens the moment an acceptable request is present.
    assign hold = in_conv | start_req;
    assign busy = in_conv;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         cs_n,
    input logic         rd_n,
    input logic         byte_sel,
    input logic         hold,
    input logic         busy,
    input logic [W-1:0] bus_q,
    input logic         bus_oe
);
    logic [7:0] run;

    always_ff @(posedge clk) begin
        if (rst)       run <= '0;
        else if (busy) run <= run + 1'b1;
        else           run <= '0;
    end

    AST_OE_SELECTED: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> (!cs_n && !rd_n)); // R8

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        busy |-> hold); // R3

    AST_ACQ_SAMPLES: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !hold); // R3

    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run == 8'(W))); // R4

    AST_FRAME_GAP: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |=> !busy ##1 !busy ##1 !busy); // R4

    AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_oe && $past(bus_oe) && $stable(byte_sel)) |-> $stable(bus_q)); // R10
endmodule

bind sar_seq_top sar_seq_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .byte_sel (byte_sel),
    .hold     (hold),
    .busy     (busy),
    .bus_q    (bus_q),
    .bus_oe   (bus_oe)
);

// File: tb/sar_seq_top_tb.sv
`timescale 1ns/1ps
module sar_seq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_n = 1'b1;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        byte_sel = 1'b0;
    logic        cmp_in;
    logic [15:0] dac_word;
    logic        hold;
    logic        busy;
    logic [15:0] bus_q;
    logic        bus_oe;

    logic [15:0] vin = 16'h0000;   // analog input, offset binary

    int checks = 0;
    int errors = 0;
    bit live = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    // Ideal comparator: 1 when the DAC level is at or below the input.
    assign cmp_in = (dac_word <= vin);

    sar_seq_top dut_i (
        .clk(clk), .rst(rst), .conv_n(conv_n), .cs_n(cs_n), .rd_n(rd_n),
        .byte_sel(byte_sel), .cmp_in(cmp_in), .dac_word(dac_word),
        .hold(hold), .busy(busy), .bus_q(bus_q), .bus_oe(bus_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural model: frame position, previous request level, stored word.
    int          m_pos = 0;
    bit          m_prev = 1'b1;
    bit          m_busy = 1'b0;
    logic [15:0] m_res = '0;
    logic [15:0] m_vin = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_pos = 0; m_prev = 1'b1; m_busy = 1'b0; m_res = '0;
        end else begin
            if (m_pos == 0) begin
                if (m_prev && !conv_n && !cs_n) begin
                    m_pos = 1; m_busy = 1'b1; m_vin = vin;
                end
            end else if (m_pos == 16) begin
                m_res = m_vin ^ 16'h8000;
                m_busy = 1'b0;
                m_pos = 17;
            end else if (m_pos == 19) begin
                m_pos = 0;
            end else begin
                m_pos++;
            end
            m_prev = conv_n;
        end
    end

    // Compare every clock, half a period after the edge.
    always @(negedge clk) begin
        if (live) begin
            bit          exp_hold;
            bit          exp_oe;
            logic [15:0] exp_q;
            exp_hold = m_busy || (m_pos == 0 && m_prev && !conv_n && !cs_n);
            exp_oe   = !cs_n && !rd_n;
            exp_q    = byte_sel ? {8'h00, m_res[15:8]} : m_res;
            chk("R4 busy", busy, m_busy);
            chk("R3 hold", hold, exp_hold);
            chk("R8 bus_oe", bus_oe, exp_oe);
            chk("R6/R9/R10 bus_q", bus_q, exp_q);
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Request pulse: low for one edge, then back high.
    task automatic pulse_conv();
        conv_n = 1'b0;
        tick(1);
        conv_n = 1'b1;
    endtask

    task automatic convert(input logic [15:0] v);
        vin = v;
        cs_n = 1'b0;
        pulse_conv();
        tick(24);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst = 1'b0;
        #0.5;
        // R1: reset state
        chk("R1 busy", busy, 1'b0);
        chk("R1 hold", hold, 1'b0);
        chk("R1 bus_oe", bus_oe, 1'b0);
        cs_n = 1'b0; rd_n = 1'b0; #0.5;
        chk("R1 result", bus_q, 16'h0000);
        rd_n = 1'b1; cs_n = 1'b1;
        live = 1'b1;
        tick(2);

        // R2: fall with chip select high starts nothing
        vin = 16'h1234;
        pulse_conv();
        tick(3);
        chk("R2 no start with cs_n high", busy, 1'b0);

        // R3/R5: hold before edge, MSB trial at clock 1, decision at clock 2
        cs_n = 1'b0;
        conv_n = 1'b0;
        #0.5;
        chk("R3 hold before edge", hold, 1'b1);
        chk("R3 busy not yet", busy, 1'b0);
        tick(1);
        conv_n = 1'b1;
        chk("R5 first trial", dac_word, 16'h8000);
        tick(1);
        chk("R5 MSB dropped, next trial", dac_word, 16'h4000);
        tick(1);
        chk("R5 bit14 dropped, next trial", dac_word, 16'h2000);
        // R7: extra pulses during the frame are discarded
        pulse_conv();
        tick(3);
        pulse_conv();
        tick(20);
        chk("R6 mid code", 32'(m_res), 32'(16'h1234 ^ 16'h8000));
        chk("R7 idle after frame", busy, 1'b0);

        // R6: corner codes
        convert(16'hFFFF);
        chk("R6 positive full scale", 32'(m_res), 32'h7FFF);
        convert(16'h8000);
        chk("R6 midscale", 32'(m_res), 32'h0000);
        convert(16'h0000);
        chk("R6 negative full scale", 32'(m_res), 32'h8000);

        // R10 + R9: read across the store edge while toggling byte select
        vin = 16'hA5C3;
        rd_n = 1'b0;
        pulse_conv();
        for (int i = 0; i < 22; i++) begin
            byte_sel = ~byte_sel;
            tick(1);
        end
        byte_sel = 1'b0;
        #0.5;
        chk("R10 stored word", bus_q, 16'hA5C3 ^ 16'h8000);
        byte_sel = 1'b1;
        #0.5;
        chk("R9 async upper byte", bus_q, {8'h00, 8'h25});
        byte_sel = 1'b0;
        #0.5;
        chk("R9 async full word", bus_q, 16'h25C3);
        rd_n = 1'b1;
        tick(2);

        // R7/R4: request held low through the frame end does not restart
        vin = 16'h0F0F;
        conv_n = 1'b0;
        tick(30);
        chk("R7 held low no restart", busy, 1'b0);
        conv_n = 1'b1;
        tick(2);

        // R4: back-to-back, fresh fall right at clock 21
        vin = 16'h7001;
        pulse_conv();
        tick(19);
        conv_n = 1'b0;
        tick(1);
        conv_n = 1'b1;
        chk("R4 restart at clock 21", busy, 1'b1);
        tick(24);
        chk("R6 second back-to-back result", 32'(m_res), 32'(16'h7001 ^ 16'h8000));

        live = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule